// File: doc/BRIEF.md
# Operand-Position Cluster Allocator

This block decides which of four execution clusters runs each instruction in a machine whose register file is split into four subsets. Each cluster writes results only into its own subset. Each of its two operand read ports can reach only two of the four subsets. The cluster index is therefore set by where the operands live, not picked freely. Its two bits are computed independently: the high bit from the group of the first operand's subset, and the low bit from the group of the second operand's subset.

Freedom of choice exists in two cases. A single-operand instruction may go to either cluster in a row. A commutative two-operand instruction gains a second legal cluster when its operands are exchanged, and this happens for half of the subset combinations. When two clusters are legal, the allocator uses one saturating allocation counter per cluster to pick the less loaded one. It raises a swap flag when the exchanged operand order was chosen, so that later stages read the sources in reverse. The destination subset reported is the subset owned by the chosen cluster.

One instruction is accepted per cycle. The decision appears on registered outputs in the following cycle.

Top module: `opclu_alloc_top`

## Requirements
- R1: The group of a subset index s is s[1] XOR s[0], so subsets 0 and 3 form group 0 and subsets 1 and 2 form group 1. For a two-operand instruction with neither flag set, the cluster index is {group(first), group(second)}, and swap is 0.
- R2: The reported destination subset always equals the chosen cluster index.
- R3: A monadic instruction may go to cluster {group(first), 0} or {group(first), 1}, and its second operand is ignored. The monadic flag takes precedence over the commutative flag, and swap is 0.
- R4: A commutative two-operand instruction may also go to the exchanged cluster {group(second), group(first)}. Swap is 1 exactly when that cluster is chosen and it differs from the unexchanged one.
- R5: When two clusters are legal, the one with the lower allocation count wins. On equal counts, the lower-numbered cluster wins.
- R6: Each accepted instruction adds one to the counter of its chosen cluster. A counter stops at 2^CNT_W-1 and does not wrap.
- R7: A high cnt_clr sets all counters to zero at the next clock edge. The clear wins over an increment in the same cycle, and the instruction presented in that cycle is still allocated.
- R8: An input with in_valid low produces out_valid low one cycle later and leaves all counters unchanged.
- R9: Outputs are registered: an instruction presented at one rising edge appears on the outputs after that edge. Asserting rst_n low forces out_valid low at once and zeroes the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_src_a | input | 2 | Subset index of the first source operand |
| in_src_b | input | 2 | Subset index of the second source operand |
| in_monadic | input | 1 | The instruction has a single source operand |
| in_commut | input | 1 | The two-operand operation is commutative |
| cnt_clr | input | 1 | Synchronous clear of all allocation counters |
| out_valid | output | 1 | An allocation decision is present |
| out_cluster | output | 2 | Chosen execution cluster |
| out_dest_subset | output | 2 | Register subset for the destination |
| out_swap | output | 1 | The operands must be exchanged |

## Verification
A counter clear and an allocation can fall in the same cycle. The bench drives cnt_clr high together with an instruction that targets cluster 0 while all counters are saturated. It then presents two monadic instructions that choose between clusters 0 and 1. The first must go to cluster 0 and the second to cluster 1, which shows that the clear zeroed every counter and that the allocation made in the clear cycle left no increment behind. The allocated instruction of the clear cycle must also appear on the outputs as usual.

// File: rtl/opclu_pkg.sv
package opclu_pkg;
  localparam int NUM_CL = 4;
  localparam int CL_W   = $clog2(NUM_CL);

  typedef logic [CL_W-1:0] cl_idx_t;

  typedef struct packed {
    logic    two_legal;
    cl_idx_t prim;
    cl_idx_t alt;
    logic    alt_swaps;
  } cand_t;
endpackage

// File: rtl/opclu_route.sv
module opclu_route
  import opclu_pkg::*;
(
  input  logic [CL_W-1:0] src_a,
  input  logic [CL_W-1:0] src_b,
  input  logic            monadic,
  input  logic            commut,
  output cand_t           cand
);
  logic grp_a;
  logic grp_b;

  always_comb begin
    grp_a = ^src_a;
    grp_b = ^src_b;
    cand  = '0;
    if (monadic) begin
      cand.prim      = {grp_a, 1'b0};
      cand.alt       = {grp_a, 1'b1};
      cand.two_legal = 1'b1;
      cand.alt_swaps = 1'b0;
    end else begin
      cand.prim      = {grp_a, grp_b};
      cand.alt       = {grp_b, grp_a};
      cand.two_legal = commut & (grp_a ^ grp_b);
      cand.alt_swaps = 1'b1;
    end
  end
endmodule

// File: rtl/opclu_pick.sv
module opclu_pick
  import opclu_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  cand_t                     cand,
  input  logic [NUM_CL*CNT_W-1:0]   counts,
  output cl_idx_t                   chosen,
  output logic                      swap
);
  logic [CNT_W-1:0] cnt_prim;
  logic [CNT_W-1:0] cnt_alt;
  logic             take_alt;

  always_comb begin
    cnt_prim = counts[cand.prim*CNT_W +: CNT_W];
    cnt_alt  = counts[cand.alt*CNT_W +: CNT_W];
    take_alt = cand.two_legal &
               ((cnt_alt < cnt_prim) ||
                ((cnt_alt == cnt_prim) && (cand.alt < cand.prim)));
    chosen   = take_alt ? cand.alt : cand.prim;
    swap     = take_alt & cand.alt_swaps;
  end
endmodule

// File: rtl/opclu_counters.sv
module opclu_counters
  import opclu_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    inc_en,
  input  cl_idx_t                 inc_sel,
  output logic [NUM_CL*CNT_W-1:0] counts
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < NUM_CL; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_en;

    always_comb begin
      cnt_en = clr | (inc_en && (inc_sel == cl_idx_t'(g)) && (cnt_q != CNT_MAX));
      cnt_d  = clr ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign counts[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/opclu_alloc_top.sv
module opclu_alloc_top
  import opclu_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_src_a,
  input  logic [1:0] in_src_b,
  input  logic       in_monadic,
  input  logic       in_commut,
  input  logic       cnt_clr,
  output logic       out_valid,
  output logic [1:0] out_cluster,
  output logic [1:0] out_dest_subset,
  output logic       out_swap
);
  logic                    rst_s1_q;
  logic                    rst_q_n;
  cand_t                   cand;
  logic [NUM_CL*CNT_W-1:0] counts;
  cl_idx_t                 chosen;
  logic                    pick_swap;

  logic    vld_d;
  cl_idx_t cl_d;
  cl_idx_t dst_d;
  logic    swp_d;
  logic    dec_en;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q_n  <= rst_s1_q;
    end
  end

  opclu_route u_route (
    .src_a   (in_src_a),
    .src_b   (in_src_b),
    .monadic (in_monadic),
    .commut  (in_commut),
    .cand    (cand)
  );

  opclu_pick #(.CNT_W(CNT_W)) u_pick (
    .cand   (cand),
    .counts (counts),
    .chosen (chosen),
    .swap   (pick_swap)
  );

  opclu_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr     (cnt_clr),
    .inc_en  (in_valid),
    .inc_sel (chosen),
    .counts  (counts)
  );

  always_comb begin
    vld_d  = in_valid;
    dec_en = in_valid;
    cl_d   = chosen;
    dst_d  = chosen;
    swp_d  = pick_swap;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_cluster     <= '0;
      out_dest_subset <= '0;
      out_swap        <= 1'b0;
    end else if (dec_en) begin
      out_cluster     <= cl_d;
      out_dest_subset <= dst_d;
      out_swap        <= swp_d;
    end
  end
endmodule

// File: rtl/opclu_alloc_chk.sv
module opclu_alloc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_src_a,
  input logic [1:0] in_src_b,
  input logic       in_monadic,
  input logic       in_commut,
  input logic       out_valid,
  input logic [1:0] out_cluster,
  input logic [1:0] out_dest_subset,
  input logic       out_swap
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  dest_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_dest_subset == out_cluster));

  // R1
  fixed_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_monadic && !in_commut) |=>
      (out_cluster == {$past(^in_src_a), $past(^in_src_b)}) && !out_swap);

  // R3
  monadic_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_monadic) |=>
      (out_cluster[1] == $past(^in_src_a)) && !out_swap);

  // R4
  commut_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_commut && !in_monadic) |=>
      ((out_cluster == {$past(^in_src_a), $past(^in_src_b)}) && !out_swap) ||
      ((out_cluster == {$past(^in_src_b), $past(^in_src_a)}) && out_swap));
endmodule

bind opclu_alloc_top opclu_alloc_chk u_alloc_chk (
  .clk             (clk),
  .rst_n           (rst_q_n),
  .in_valid        (in_valid),
  .in_src_a        (in_src_a),
  .in_src_b        (in_src_b),
  .in_monadic      (in_monadic),
  .in_commut       (in_commut),
  .out_valid       (out_valid),
  .out_cluster     (out_cluster),
  .out_dest_subset (out_dest_subset),
  .out_swap        (out_swap)
);

// File: tb/test_opclu_alloc_top.sv
module test_opclu_alloc_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [1:0] in_src_a;
  logic [1:0] in_src_b;
  logic       in_monadic;
  logic       in_commut;
  logic       cnt_clr;
  logic       out_valid;
  logic [1:0] out_cluster;
  logic [1:0] out_dest_subset;
  logic       out_swap;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5ns clk = ~clk;

  opclu_alloc_top #(.CNT_W(2)) i_opclu_alloc_top (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_src_a        (in_src_a),
    .in_src_b        (in_src_b),
    .in_monadic      (in_monadic),
    .in_commut       (in_commut),
    .cnt_clr         (cnt_clr),
    .out_valid       (out_valid),
    .out_cluster     (out_cluster),
    .out_dest_subset (out_dest_subset),
    .out_swap        (out_swap)
  );

  typedef struct packed {
    logic       v;
    logic [1:0] a;
    logic [1:0] b;
    logic       mon;
    logic       com;
    logic       ev;
    logic [1:0] ecl;
    logic       esw;
    logic [3:0] req;
  } vec_t;

  // counters saturate at 3 in this bench (CNT_W = 2)
  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 4'd1}, // R1 plain
    '{1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd1}, // R1 plain
    '{1'b1, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 4'd5}, // R5 lower count
    '{1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 4'd3}, // R3 monadic row
    '{1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd5}, // R5 tie
    '{1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 4'd5}, // R5 tie, no swap
    '{1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 4'd4}, // R4 primary kept
    '{1'b1, 2'd2, 2'd3, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 4'd4}, // R4 swap taken
    '{1'b1, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 4'd4}, // R4 same group
    '{1'b1, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 4'd4}, // R4 same group
    '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd8}, // R8 idle
    '{1'b1, 2'd1, 2'd3, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 4'd8}, // R8 counts kept
    '{1'b1, 2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 4'd5}, // R5
    '{1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 4'd6}, // R6 c1 at max
    '{1'b1, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd6}, // R6 no wrap
    '{1'b1, 2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 4'd3}  // R3 precedence
  };

  task automatic drive(input logic v, input logic [1:0] a, input logic [1:0] b,
                       input logic mon, input logic com, input logic clr);
    in_valid   = v;
    in_src_a   = a;
    in_src_b   = b;
    in_monadic = mon;
    in_commut  = com;
    cnt_clr    = clr;
  endtask

  task automatic check(input string req, input logic ev, input logic [1:0] ecl,
                       input logic esw);
    n_chk++;
    if (out_valid !== ev ||
        (ev && (out_cluster !== ecl || out_dest_subset !== ecl || out_swap !== esw))) begin
      n_fail++;
      $display("FAIL %s: got v=%0b cl=%0d dst=%0d sw=%0b, want v=%0b cl=%0d dst=%0d sw=%0b",
               req, out_valid, out_cluster, out_dest_subset, out_swap, ev, ecl, ecl, esw);
    end
  endtask

  task automatic step(input string req, input logic v, input logic [1:0] a,
                      input logic [1:0] b, input logic mon, input logic com,
                      input logic clr, input logic ev, input logic [1:0] ecl,
                      input logic esw);
    drive(v, a, b, mon, com, clr);
    @(negedge clk);
    drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check(req, ev, ecl, esw);
  endtask

  initial begin
    drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0, 2'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 after release", 1'b0, 2'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].v, TBL[i].a,
           TBL[i].b, TBL[i].mon, TBL[i].com, 1'b0, TBL[i].ev, TBL[i].ecl, TBL[i].esw);
    end

    // R7: clear with a same-cycle allocation to cluster 0
    step("R7 clear cycle", 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0);
    step("R7 all zero", 1'b1, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
    step("R7 R6 count one", 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0);
    step("R6 c1 ahead", 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);

    // R9: asynchronous reset mid-run clears counters (c0=2, c1=1 before)
    drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    #1ns rst_n = 1'b0;
    #0.5ns check("R9 async reset", 1'b0, 2'd0, 1'b0);
    drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step("R9 counters zeroed", 1'b1, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung, want completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule